// File: doc/BRIEF.md
# Multi-Mode Operand Addressing Unit

This unit executes the accumulate step `Rd <- Rd + operand` for one instruction at a time. The source operand is found through one of ten addressing modes. The caller presents a mode code, three register selectors (destination, base and index), a literal used as immediate, displacement or absolute address, and an operand-size code, then pulses `start`. The unit holds an eight-entry register file. It issues single reads to a byte-addressed data memory, whose read data appears one cycle after the request. It writes the sum to the destination register and, in the two auto-modifying modes, also updates the base register.

Sequencing is done by a state machine with seven states. `IDLE` waits for `start` and goes to `WRITE` for the register and immediate modes, to `FAULT` for an undefined code, and to `READ1` for every memory mode. `READ1` drives the request and moves to `LOAD1`. `LOAD1` captures the returned word; from there the memory-indirect mode goes to `READ2` and every other mode goes to `WRITE`. `READ2` requests the word at the captured pointer and moves to `LOAD2`, which captures the operand and moves to `WRITE`. `WRITE` commits the register updates and returns to `IDLE`. `FAULT` returns to `IDLE` without touching any register. `done` is a one-cycle pulse in the cycle after `WRITE` or `FAULT`. A peek port gives a combinational view of any register.

Top module: `opaddr_unit`

## Requirements
- R1: After reset, all eight registers read zero, and `done`, `illegal`, `busy` and `mem_rd_en` are low.
- R2: Mode 0 (register) adds the value of the base-selected register to Rd, makes no memory read, and raises `done` two cycles after `start` is sampled.
- R3: Mode 1 (immediate) adds `imm` to Rd without a memory read, with the same two-cycle latency as R2.
- R4: Mode 2 (displacement) reads at `imm + base`. Mode 3 (register indirect) reads at `base`. Each adds the loaded word to Rd.
- R5: Mode 4 (indexed) reads at `base + index`. Mode 5 (absolute) reads at `imm`. Each adds the loaded word to Rd.
- R6: Mode 6 (memory indirect) reads at `base`, then reads at the returned word, then adds the second word to Rd. It makes exactly two reads, and `done` comes 6 cycles after `start`.
- R7: Mode 7 (post-increment) reads at `base`, adds the word to Rd and adds d to the base register.
- R8: Mode 8 (auto-decrement) reads at `base`, adds the word to Rd and subtracts d from the base register.
- R9: Mode 9 (scaled) reads at `imm + base + (index << size_sel)`.
- R10: `size_sel` values 0, 1, 2 and 3 give d = 1, 2, 4 and 8 bytes.
- R11: When Rd is also the base register of mode 7 or 8, the register ends up holding the sum, not the adjusted base.
- R12: Mode codes 10 to 15 raise `illegal` together with `done`, make no memory read and leave every register unchanged.
- R13: Every single-read mode takes exactly one read, with `done` 4 cycles after `start`; `done` is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| mode | input | 4 | Addressing mode code |
| rd_sel | input | 3 | Destination register |
| base_sel | input | 3 | Base / second source register |
| index_sel | input | 3 | Index register |
| imm | input | 32 | Immediate, displacement or absolute address |
| size_sel | input | 2 | Operand size code, d = 1 << size_sel |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after the request |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle retire pulse |
| illegal | output | 1 | Undefined mode, pulses with done |
| peek_sel | input | 3 | Register selected for observation |
| peek_data | output | 32 | Value of the selected register |

## Verification
The bench targets the memory-indirect chain. A design that reused the first address or took the data one cycle early would issue the wrong second address and add the pointer instead of the operand. It checks the Rd-equals-base collision, where a wrong write priority leaves the adjusted base in place of the sum. Every size code is exercised through the scaled and auto-modifying modes, so a wrong shift amount or step shows up as a wrong read address or base value. Undefined codes are mixed into random traffic, and every register is compared afterwards, so a design that partly executed them would show a changed register or a stray read.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

    localparam logic [3:0] AM_REG   = 4'd0;
    localparam logic [3:0] AM_IMM   = 4'd1;
    localparam logic [3:0] AM_DISP  = 4'd2;
    localparam logic [3:0] AM_RIND  = 4'd3;
    localparam logic [3:0] AM_IDX   = 4'd4;
    localparam logic [3:0] AM_ABS   = 4'd5;
    localparam logic [3:0] AM_MIND  = 4'd6;
    localparam logic [3:0] AM_PINC  = 4'd7;
    localparam logic [3:0] AM_PDEC  = 4'd8;
    localparam logic [3:0] AM_SCALE = 4'd9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ1,
        ST_LOAD1,
        ST_READ2,
        ST_LOAD2,
        ST_WRITE,
        ST_FAULT
    } seq_state_e;

    function automatic logic mode_legal(input logic [3:0] m);
        return (m <= AM_SCALE);
    endfunction

    function automatic logic mode_no_mem(input logic [3:0] m);
        return (m == AM_REG) || (m == AM_IMM);
    endfunction

endpackage

// File: rtl/opaddr_regfile.sv
module opaddr_regfile #(
    parameter int W    = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic [IW-1:0] rc_idx,
    output logic [W-1:0]  rc_data,
    input  logic [IW-1:0] rp_idx,
    output logic [W-1:0]  rp_data,
    input  logic          wa_en,
    input  logic [IW-1:0] wa_idx,
    input  logic [W-1:0]  wa_data,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  logic [W-1:0]  wb_data
);

    logic [W-1:0] q [NREG];

    // Port B (destination sum) takes priority over port A (base update).
    for (genvar i = 0; i < NREG; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= '0;
            end else if (wb_en && (wb_idx == IW'(i))) begin
                q[i] <= wb_data;
            end else if (wa_en && (wa_idx == IW'(i))) begin
                q[i] <= wa_data;
            end
        end
    end

    assign ra_data = q[ra_idx];
    assign rb_data = q[rb_idx];
    assign rc_data = q[rc_idx];
    assign rp_data = q[rp_idx];

    // R11: on a same-index collision the destination value survives
    a_r11_dest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en && (wa_idx == wb_idx)) |=> (q[$past(wb_idx)] == $past(wb_data)));

endmodule

// File: rtl/opaddr_ea.sv
module opaddr_ea
    import opaddr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [3:0]   mode,
    input  logic [W-1:0] base,
    input  logic [W-1:0] index,
    input  logic [W-1:0] imm,
    input  logic [1:0]   size_sel,
    output logic [W-1:0] ea,
    output logic [W-1:0] base_next,
    output logic         base_upd
);

    logic [W-1:0] step;
    logic [W-1:0] scaled_idx;

    assign step       = W'(1) << size_sel;
    assign scaled_idx = index << size_sel;

    always_comb begin
        ea = base;
        case (mode)
            AM_DISP:  ea = imm + base;
            AM_IDX:   ea = base + index;
            AM_ABS:   ea = imm;
            AM_SCALE: ea = imm + base + scaled_idx;
            default:  ea = base;
        endcase
    end

    always_comb begin
        base_upd  = 1'b0;
        base_next = base;
        case (mode)
            AM_PINC: begin
                base_upd  = 1'b1;
                base_next = base + step;
            end
            AM_PDEC: begin
                base_upd  = 1'b1;
                base_next = base - step;
            end
            default: begin
                base_upd  = 1'b0;
                base_next = base;
            end
        endcase
    end

endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
    import opaddr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [3:0]   mode_in,
    input  logic [W-1:0] ea,
    input  logic [W-1:0] mem_rdata,
    output logic [3:0]   mode_q,
    output logic [W-1:0] opnd_q,
    output logic         mem_rd_en,
    output logic [W-1:0] mem_addr,
    output logic         wb_en,
    output logic         idle,
    output logic         done,
    output logic         illegal
);

    seq_state_e state, state_nx;
    logic       done_q, illegal_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!mode_legal(mode_in))      state_nx = ST_FAULT;
                    else if (mode_no_mem(mode_in)) state_nx = ST_WRITE;
                    else                           state_nx = ST_READ1;
                end
            end
            ST_READ1: state_nx = ST_LOAD1;
            ST_LOAD1: state_nx = (mode_q == AM_MIND) ? ST_READ2 : ST_WRITE;
            ST_READ2: state_nx = ST_LOAD2;
            ST_LOAD2: state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_IDLE;
            ST_FAULT: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= '0;
            opnd_q    <= '0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            if ((state == ST_IDLE) && start) mode_q <= mode_in;
            if ((state == ST_LOAD1) || (state == ST_LOAD2)) opnd_q <= mem_rdata;
            done_q    <= (state == ST_WRITE) || (state == ST_FAULT);
            illegal_q <= (state == ST_FAULT);
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        wb_en     = 1'b0;
        unique case (state)
            ST_READ1: begin
                mem_rd_en = 1'b1;
                mem_addr  = ea;
            end
            ST_READ2: begin
                mem_rd_en = 1'b1;
                mem_addr  = opnd_q;
            end
            ST_WRITE: wb_en = 1'b1;
            default: begin
                mem_rd_en = 1'b0;
                mem_addr  = '0;
                wb_en     = 1'b0;
            end
        endcase
    end

    assign idle    = (state == ST_IDLE);
    assign done    = done_q;
    assign illegal = illegal_q;

    // R6: second request points at the word returned by the first
    a_r6_chain_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ2) |-> (mem_addr == $past(mem_rdata)));

    // R6: a request is always followed by a cycle without one
    a_r6_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R13: retire pulse lasts one cycle
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: an illegal retire is preceded by no memory request
    a_r12_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !$past(mem_rd_en)));

    // R12: a fault always reports
    a_r12_fault_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |=> (illegal && idle));

endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
    import opaddr_pkg::*;
#(
    parameter int W    = 32,
    parameter int NREG = 8,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [IW-1:0] rd_sel,
    input  logic [IW-1:0] base_sel,
    input  logic [IW-1:0] index_sel,
    input  logic [W-1:0]  imm,
    input  logic [1:0]    size_sel,
    output logic          mem_rd_en,
    output logic [W-1:0]  mem_addr,
    input  logic [W-1:0]  mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          illegal,
    input  logic [IW-1:0] peek_sel,
    output logic [W-1:0]  peek_data
);

    logic [IW-1:0] rd_q, rs_q, rx_q;
    logic [W-1:0]  imm_q;
    logic [1:0]    sz_q;
    logic [3:0]    mode_q;
    logic [W-1:0]  opnd_q;
    logic [W-1:0]  base_val, idx_val, rd_val;
    logic [W-1:0]  ea, base_next, operand, sum;
    logic          base_upd, wb_en, idle;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            rs_q  <= '0;
            rx_q  <= '0;
            imm_q <= '0;
            sz_q  <= '0;
        end else if (idle && start) begin
            rd_q  <= rd_sel;
            rs_q  <= base_sel;
            rx_q  <= index_sel;
            imm_q <= imm;
            sz_q  <= size_sel;
        end
    end

    opaddr_regfile #(.W(W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (rs_q),
        .ra_data (base_val),
        .rb_idx  (rx_q),
        .rb_data (idx_val),
        .rc_idx  (rd_q),
        .rc_data (rd_val),
        .rp_idx  (peek_sel),
        .rp_data (peek_data),
        .wa_en   (wb_en && base_upd),
        .wa_idx  (rs_q),
        .wa_data (base_next),
        .wb_en   (wb_en),
        .wb_idx  (rd_q),
        .wb_data (sum)
    );

    opaddr_ea #(.W(W)) u_ea (
        .mode      (mode_q),
        .base      (base_val),
        .index     (idx_val),
        .imm       (imm_q),
        .size_sel  (sz_q),
        .ea        (ea),
        .base_next (base_next),
        .base_upd  (base_upd)
    );

    opaddr_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mode_in   (mode),
        .ea        (ea),
        .mem_rdata (mem_rdata),
        .mode_q    (mode_q),
        .opnd_q    (opnd_q),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .wb_en     (wb_en),
        .idle      (idle),
        .done      (done),
        .illegal   (illegal)
    );

    always_comb begin
        case (mode_q)
            AM_REG:  operand = base_val;
            AM_IMM:  operand = imm_q;
            default: operand = opnd_q;
        endcase
    end

    assign sum  = rd_val + operand;
    assign busy = !idle;

endmodule

// File: tb/sim_opaddr_unit.sv
module sim_opaddr_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [2:0]  rd_sel = '0, base_sel = '0, index_sel = '0, peek_sel = '0;
    logic [31:0] imm = '0;
    logic [1:0]  size_sel = '0;
    logic        mem_rd_en, busy, done, illegal;
    logic [31:0] mem_addr, peek_data;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int failures = 0;
    logic [31:0] mrf [8];

    int          nreads;
    logic [31:0] raddr0, raddr1;

    always #4 clk = ~clk;

    opaddr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .rd_sel(rd_sel), .base_sel(base_sel), .index_sel(index_sel),
        .imm(imm), .size_sel(size_sel), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .illegal(illegal), .peek_sel(peek_sel),
        .peek_data(peek_data)
    );

    function automatic logic [31:0] memf(input logic [31:0] a);
        return ((a ^ 32'h5A5A_0F0F) * 32'h0001_0003) + 32'h0123_4567;
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= memf(mem_addr);
            if (nreads == 0) raddr0 <= mem_addr;
            if (nreads == 1) raddr1 <= mem_addr;
            nreads <= nreads + 1;
        end
    end

    function automatic string tag_of(input logic [3:0] m);
        case (m)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            4'd9: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 8; i++) begin
            peek_sel = 3'(i);
            #1;
            check(tag, peek_data, mrf[i]);
        end
    endtask

    task automatic exec(input logic [3:0] m, input logic [2:0] rd, input logic [2:0] rs,
                        input logic [2:0] rx, input logic [31:0] im, input logic [1:0] sz);
        logic [31:0] base, idx, d, ea, opnd, old_rd;
        int          exp_reads, exp_lat, cnt;
        logic        bad;
        string       tg;
        tg   = tag_of(m);
        base = mrf[rs];
        idx  = mrf[rx];
        d    = 32'd1 << sz;
        bad  = (m > 4'd9);
        case (m)
            4'd2:    ea = im + base;
            4'd4:    ea = base + idx;
            4'd5:    ea = im;
            4'd9:    ea = im + base + (idx << sz);
            default: ea = base;
        endcase
        case (m)
            4'd0:    opnd = base;
            4'd1:    opnd = im;
            4'd6:    opnd = memf(memf(base));
            default: opnd = memf(ea);
        endcase
        exp_reads = (bad || m <= 4'd1) ? 0 : (m == 4'd6 ? 2 : 1);
        exp_lat   = (bad || m <= 4'd1) ? 2 : (m == 4'd6 ? 6 : 4);
        if (!bad) begin
            old_rd = mrf[rd];
            if (m == 4'd7) mrf[rs] = base + d;
            if (m == 4'd8) mrf[rs] = base - d;
            mrf[rd] = old_rd + opnd;
        end
        @(negedge clk);
        nreads = 0;
        mode = m; rd_sel = rd; base_sel = rs; index_sel = rx; imm = im; size_sel = sz;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 20) begin
            @(posedge clk);
            @(negedge clk);
            cnt++;
        end
        check(exp_lat == 2 && !bad ? tg : (bad ? "R12" : (m == 4'd6 ? "R6" : "R13")),
              32'(cnt), 32'(exp_lat));
        check(bad ? "R12" : tg, {31'd0, illegal}, {31'd0, bad});
        @(negedge clk);
        check("R13", {31'd0, done}, 32'd0);
        check(m == 4'd6 ? "R6" : (bad ? "R12" : "R13"), 32'(nreads), 32'(exp_reads));
        if (exp_reads >= 1) check(tg, raddr0, ea);
        if (exp_reads == 2) check("R6", raddr1, memf(base));
        check_regs(tg);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) mrf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", {28'd0, done, illegal, busy, mem_rd_en}, 32'd0);
        check_regs("R1");

        // load registers through immediate mode (R3)
        for (int i = 0; i < 8; i++) exec(4'd1, 3'(i), 3'(i), 3'(i), 32'h100 * (i + 1) + 32'h10, 2'd0);
        // register direct (R2)
        exec(4'd0, 3'd0, 3'd5, 3'd0, 32'd0, 2'd0);
        // displacement / indirect / indexed / absolute (R4, R5)
        exec(4'd2, 3'd1, 3'd2, 3'd0, 32'h40, 2'd0);
        exec(4'd3, 3'd2, 3'd3, 3'd0, 32'd0, 2'd0);
        exec(4'd4, 3'd3, 3'd4, 3'd5, 32'd0, 2'd0);
        exec(4'd5, 3'd4, 3'd0, 3'd0, 32'hDEAD_0000, 2'd0);
        // memory indirect (R6)
        exec(4'd6, 3'd5, 3'd6, 3'd0, 32'd0, 2'd0);
        // every size code on post-increment, auto-decrement, scaled (R7, R8, R9, R10)
        for (int s = 0; s < 4; s++) begin
            exec(4'd7, 3'd0, 3'd1, 3'd0, 32'd0, 2'(s));
            exec(4'd8, 3'd2, 3'd3, 3'd0, 32'd0, 2'(s));
            exec(4'd9, 3'd4, 3'd5, 3'd6, 32'h20, 2'(s));
        end
        // R11 destination equals modified base
        exec(4'd7, 3'd6, 3'd6, 3'd0, 32'd0, 2'd2);
        exec(4'd8, 3'd7, 3'd7, 3'd0, 32'd0, 2'd3);
        // R12 every undefined code
        for (int m = 10; m < 16; m++) exec(4'(m), 3'd1, 3'd2, 3'd3, 32'h55, 2'd1);
        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic [3:0] rm;
            rm = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(10, 15)) : 4'($urandom_range(0, 9));
            exec(rm, 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                 $urandom(), 2'($urandom_range(0, 3)));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule